// File: doc/BRIEF.md
# Hexadecimal Record Stream Loader

This block accepts a stream of ASCII characters, one per cycle in which `in_valid` is high, and decodes the records of the Intel HEX text format. A record opens with a colon. It then carries a byte count, a 16-bit load address, a record type, the data bytes and a one-byte checksum. Each byte is written as two hexadecimal characters.

Data bytes are turned into memory write strobes as soon as each one is complete. The first write goes to the record's load address, and each later write goes to the next address. The block keeps a running sum of every byte in the record and reports a checksum failure when the record ends. It reports malformed input as a framing error and drops the rest of that record. When a well-formed end-of-file record arrives, it raises a done flag.

A loader places this block between a serial receiver and a memory write port. No buffering is needed, because no record has to be held back before its bytes are written.

Top module: `ihex_loader`

## Requirements
- R1: A record starts only on an accepted colon (3Ah). Any other accepted character outside a record, including carriage return and line feed, produces no write, no error and no change of `eof_done`.
- R2: A count byte above 10h produces a one-cycle `frame_err` pulse in the cycle after its second character. The rest of that record is then dropped, with no writes and no checksum report.
- R3: Each byte is two hexadecimal characters, upper nibble first. The characters 0-9, A-F and a-f are accepted with the same meaning.
- R4: In a record of type 00h, each data byte produces a one-cycle `wr_en` pulse in the cycle after its second character is accepted, with `wr_data` set to that byte. The address field is sent high byte first. The n-th data byte (n from 0) is written to load address + n, modulo 2^16.
- R5: A non-hexadecimal character inside a record, or a colon before the record's checksum is complete, produces a one-cycle `frame_err` pulse and drops the rest of the record. A colon also starts a new record.
- R6: When the checksum byte completes, if the low byte of the sum of all record bytes, checksum included, is not 00h, `csum_err` pulses for one cycle. This happens in the cycle after the checksum's second character. Writes already issued for the record stand.
- R7: A type 01h record with a correct checksum sets `eof_done` in the cycle after its last character. The flag stays high until reset or until the next accepted colon.
- R8: A record of any type other than 00h produces no writes. Its checksum is still checked.
- R9: After reset, `wr_en`, `csum_err`, `frame_err` and `eof_done` are low and no record is open.
- R10: A record whose count is 00h goes straight from the type byte to the checksum byte.
- R11: A character presented while `in_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character on `in_char` is accepted this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| csum_err | output | 1 | One-cycle pulse: record checksum failed |
| frame_err | output | 1 | One-cycle pulse: malformed record dropped |
| eof_done | output | 1 | End-of-file record received intact |

## Verification
An address register that fails to advance, or a nibble phase that slips, shows up in the next write of the same record. The fault is visible at the ports within two accepted characters. A running sum that is not cleared at the colon survives through the whole record, so it shows only as a wrong `csum_err` one cycle after the final character. A wrong record state after an error shows up as writes or checksum reports from a record that should have been dropped. The bench therefore compares every write and every pulse against a model of each record, across random gaps, letter case and corrupted checksums.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

    localparam int ADDR_W = 16;
    localparam logic [7:0] REC_DATA = 8'h00;
    localparam logic [7:0] REC_EOF  = 8'h01;
    localparam logic [7:0] CH_COLON = 8'h3A;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_COUNT,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_TYPE,
        ST_DATA,
        ST_CSUM
    } rec_state_e;

    typedef struct packed {
        logic       is_hex;
        logic       is_colon;
        logic [3:0] nib;
    } char_info_t;

    function automatic char_info_t classify(input logic [7:0] c);
        char_info_t r;
        r.is_colon = (c == CH_COLON);
        r.is_hex   = 1'b0;
        r.nib      = 4'h0;
        if (c >= 8'h30 && c <= 8'h39) begin
            r.is_hex = 1'b1;
            r.nib    = c[3:0];
        end else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
            r.is_hex = 1'b1;
            r.nib    = c[3:0] + 4'd9;
        end
        return r;
    endfunction

endpackage

// File: rtl/ihex_char_class.sv
module ihex_char_class
    import ihex_pkg::*;
(
    input  logic [7:0] ch,
    output char_info_t info
);
    always_comb begin
        info = classify(ch);
    end
endmodule

// File: rtl/ihex_byte_pack.sv
module ihex_byte_pack (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       is_hex,
    input  logic [3:0] nib,
    input  logic       active,
    output logic       byte_stb,
    output logic [7:0] byte_val
);
    logic       have_hi;
    logic [3:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            have_hi <= 1'b0;
            hi_q    <= 4'h0;
        end else if (in_valid) begin
            if (is_hex) begin
                if (!have_hi) begin
                    hi_q    <= nib;
                    have_hi <= 1'b1;
                end else begin
                    have_hi <= 1'b0;
                end
            end else begin
                have_hi <= 1'b0;
            end
        end
    end

    assign byte_stb = active && in_valid && is_hex && have_hi;
    assign byte_val = {hi_q, nib};

    AST_PAIRED_NIBBLES: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb) else $error("byte strobe on consecutive cycles"); // R3
endmodule

// File: rtl/ihex_record_seq.sv
module ihex_record_seq
    import ihex_pkg::*;
#(
    parameter int MAX_DATA = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              is_hex,
    input  logic              is_colon,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    output logic              active,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              csum_err,
    output logic              frame_err,
    output logic              eof_done
);
    localparam int CNT_W = $clog2(MAX_DATA + 1);

    rec_state_e        state_q;
    logic [7:0]        sum_q;
    logic [7:0]        sum_nx;
    logic [7:0]        rtype_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    assign sum_nx = sum_q + byte_val;
    assign active = (state_q != ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HUNT;
            sum_q     <= 8'h00;
            rtype_q   <= 8'h00;
            addr_q    <= '0;
            left_q    <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= 8'h00;
            csum_err  <= 1'b0;
            frame_err <= 1'b0;
            eof_done  <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            csum_err  <= 1'b0;
            frame_err <= 1'b0;
            if (in_valid && is_colon) begin
                frame_err <= (state_q != ST_HUNT);
                state_q   <= ST_COUNT;
                sum_q     <= 8'h00;
                eof_done  <= 1'b0;
            end else if (in_valid && active && !is_hex) begin
                frame_err <= 1'b1;
                state_q   <= ST_HUNT;
            end else if (byte_stb) begin
                sum_q <= sum_nx;
                case (state_q)
                    ST_COUNT: begin
                        if (byte_val > 8'(MAX_DATA)) begin
                            frame_err <= 1'b1;
                            state_q   <= ST_HUNT;
                        end else begin
                            left_q  <= byte_val[CNT_W-1:0];
                            state_q <= ST_ADDR_HI;
                        end
                    end
                    ST_ADDR_HI: begin
                        addr_q[15:8] <= byte_val;
                        state_q      <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        addr_q[7:0] <= byte_val;
                        state_q     <= ST_TYPE;
                    end
                    ST_TYPE: begin
                        rtype_q <= byte_val;
                        state_q <= (left_q == '0) ? ST_CSUM : ST_DATA;
                    end
                    ST_DATA: begin
                        if (rtype_q == REC_DATA) begin
                            wr_en   <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= byte_val;
                        end
                        addr_q <= addr_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_CSUM;
                        end
                    end
                    ST_CSUM: begin
                        if (sum_nx != 8'h00) begin
                            csum_err <= 1'b1;
                        end else if (rtype_q == REC_EOF) begin
                            eof_done <= 1'b1;
                        end
                        state_q <= ST_HUNT;
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en) else $error("write strobes too close"); // R4
    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (left_q != '0 && left_q <= CNT_W'(MAX_DATA))) else $error("count out of range"); // R2
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(csum_err && frame_err)) else $error("both errors at once"); // R6
    AST_CSUM_END: assert property (@(posedge clk) disable iff (rst)
        csum_err |-> (state_q == ST_HUNT && !wr_en)) else $error("checksum report mid record"); // R6
    AST_FRAME_RESYNC: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> (state_q == ST_HUNT || state_q == ST_COUNT)) else $error("frame error without resync"); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eof_done && !(in_valid && is_colon)) |=> eof_done) else $error("done dropped"); // R7
endmodule

// File: rtl/ihex_loader.sv
module ihex_loader
    import ihex_pkg::*;
#(
    parameter int MAX_DATA = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    output logic        wr_en,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        csum_err,
    output logic        frame_err,
    output logic        eof_done
);
    char_info_t info;
    logic       active;
    logic       byte_stb;
    logic [7:0] byte_val;

    ihex_char_class u_class (
        .ch   (in_char),
        .info (info)
    );

    ihex_byte_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .is_hex   (info.is_hex),
        .nib      (info.nib),
        .active   (active),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    ihex_record_seq #(.MAX_DATA(MAX_DATA)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .is_hex    (info.is_hex),
        .is_colon  (info.is_colon),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .active    (active),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .csum_err  (csum_err),
        .frame_err (frame_err),
        .eof_done  (eof_done)
    );

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        rst |=> (!wr_en && !csum_err && !frame_err && !eof_done)) else $error("outputs active after reset"); // R9
endmodule

// File: tb/test_ihex_loader.sv
module test_ihex_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        csum_err;
    logic        frame_err;
    logic        eof_done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] log_addr [0:63];
    logic [7:0]  log_data [0:63];
    int          log_n = 0;
    int          fe_n  = 0;
    int          ce_n  = 0;
    logic [7:0]  rec_data [0:31];

    always #4 clk = ~clk;

    ihex_loader i_ihex_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .csum_err(csum_err), .frame_err(frame_err), .eof_done(eof_done)
    );

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (wr_en) begin
                if (log_n < 64) begin
                    log_addr[log_n] = wr_addr;
                    log_data[log_n] = wr_data;
                end
                log_n++;
            end
            if (frame_err) fe_n++;
            if (csum_err)  ce_n++;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input logic lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
    endfunction

    task automatic clear_logs();
        log_n = 0; fe_n = 0; ce_n = 0;
    endtask

    task automatic send_char(input logic [7:0] c);
        int gap;
        gap = $urandom % 3;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_char  = 8'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic lower);
        send_char(hexch(b[7:4], lower));
        send_char(hexch(b[3:0], lower));
    endtask

    task automatic send_rec(input int cnt, input logic [15:0] addr, input logic [7:0] typ,
                            input logic bad, input logic lower);
        logic [7:0] sum;
        logic [7:0] cs;
        send_char(8'h3A);
        sum = 8'(cnt) + addr[15:8] + addr[7:0] + typ;
        send_byte(8'(cnt), lower);
        send_byte(addr[15:8], lower);
        send_byte(addr[7:0], lower);
        send_byte(typ, lower);
        for (int i = 0; i < cnt; i++) begin
            send_byte(rec_data[i], lower);
            sum = sum + rec_data[i];
        end
        cs = 8'h00 - sum;
        if (bad) cs = cs ^ 8'h5A;
        send_byte(cs, lower);
    endtask

    task automatic verify_rec(input int cnt, input logic [15:0] addr, input logic [7:0] typ,
                              input logic bad, input string tag);
        int exp_w;
        exp_w = (typ == 8'h00) ? cnt : 0;
        check(log_n == exp_w, {tag, " R4/R8 write count"}, log_n, exp_w);
        for (int i = 0; i < exp_w && i < log_n; i++) begin
            check(log_addr[i] == 16'(addr + 16'(i)), {tag, " R4 address"}, log_addr[i], 16'(addr + 16'(i)));
            check(log_data[i] == rec_data[i], {tag, " R4 data"}, log_data[i], rec_data[i]);
        end
        check(ce_n == int'(bad), {tag, " R6 checksum flag"}, ce_n, int'(bad));
        check(fe_n == 0, {tag, " R5 no framing error"}, fe_n, 0);
        if (typ == 8'h01)
            check(eof_done == !bad, {tag, " R7 done"}, eof_done, !bad);
        clear_logs();
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!wr_en && !csum_err && !frame_err && !eof_done, "R9 reset outputs", {wr_en, csum_err, frame_err, eof_done}, 0);

        // R4 exact timing, R3 nibble order
        clear_logs();
        send_char(8'h3A);
        send_byte(8'h02, 1'b0); send_byte(8'h12, 1'b0); send_byte(8'h34, 1'b0); send_byte(8'h00, 1'b0);
        send_byte(8'hAB, 1'b0);
        check(wr_en && wr_addr == 16'h1234 && wr_data == 8'hAB, "R4 first strobe timing", {wr_en, wr_addr, wr_data}, {1'b1, 16'h1234, 8'hAB});
        @(negedge clk);
        check(!wr_en, "R4 strobe one cycle", wr_en, 0);
        send_byte(8'hcd, 1'b1);
        check(wr_en && wr_addr == 16'h1235 && wr_data == 8'hCD, "R3 R4 lower-case second byte", {wr_en, wr_addr, wr_data}, {1'b1, 16'h1235, 8'hCD});
        send_byte(8'h40, 1'b0);
        check(!csum_err && !frame_err, "R6 good checksum quiet", {csum_err, frame_err}, 0);
        clear_logs();

        // R2 count above limit
        for (int i = 0; i < 17; i++) rec_data[i] = 8'(i + 1);
        send_rec(17, 16'h0100, 8'h00, 1'b0, 1'b0);
        check(fe_n == 1, "R2 count 11h framing error", fe_n, 1);
        check(log_n == 0 && ce_n == 0, "R2 record dropped", log_n + ce_n, 0);
        clear_logs();

        // R5 non-hex inside record
        send_char(8'h3A);
        send_byte(8'h03, 1'b0); send_byte(8'h00, 1'b0); send_byte(8'h10, 1'b0); send_byte(8'h00, 1'b0);
        send_byte(8'hAA, 1'b0);
        send_char("G");
        send_byte(8'hBB, 1'b0); send_byte(8'hCC, 1'b0);
        check(fe_n == 1, "R5 non-hex framing error", fe_n, 1);
        check(log_n == 1, "R5 writes before error only", log_n, 1);
        check(ce_n == 0, "R5 no checksum report", ce_n, 0);
        clear_logs();

        // R5 colon mid record then a good record
        send_char(8'h3A);
        send_byte(8'h02, 1'b0); send_byte(8'h00, 1'b0);
        rec_data[0] = 8'h5E; rec_data[1] = 8'hE5;
        send_rec(2, 16'h0020, 8'h00, 1'b0, 1'b0);
        check(fe_n == 1, "R5 colon resync error", fe_n, 1);
        fe_n = 0;
        verify_rec(2, 16'h0020, 8'h00, 1'b0, "R5 after resync");

        // R10 empty data record
        send_rec(0, 16'h4000, 8'h00, 1'b0, 1'b0);
        verify_rec(0, 16'h4000, 8'h00, 1'b0, "R10 zero count");

        // R8 other type
        rec_data[0] = 8'h12; rec_data[1] = 8'h34;
        send_rec(2, 16'h0000, 8'h02, 1'b0, 1'b0);
        verify_rec(2, 16'h0000, 8'h02, 1'b0, "R8 type 02");
        check(!eof_done, "R8 no done", eof_done, 0);

        // R6 bad checksum on data record
        rec_data[0] = 8'h99; rec_data[1] = 8'h01; rec_data[2] = 8'hF0;
        send_rec(3, 16'h2000, 8'h00, 1'b1, 1'b0);
        verify_rec(3, 16'h2000, 8'h00, 1'b1, "R6 corrupt");

        // R4 address wrap
        for (int i = 0; i < 4; i++) rec_data[i] = 8'(8'hA0 + i);
        send_rec(4, 16'hFFFE, 8'h00, 1'b0, 1'b1);
        verify_rec(4, 16'hFFFE, 8'h00, 1'b0, "R4 wrap");

        // R7 eof with bad checksum, then good
        send_rec(0, 16'h0000, 8'h01, 1'b1, 1'b0);
        verify_rec(0, 16'h0000, 8'h01, 1'b1, "R7 bad eof");
        send_rec(0, 16'h0000, 8'h01, 1'b0, 1'b0);
        verify_rec(0, 16'h0000, 8'h01, 1'b0, "R7 good eof");

        // R1 junk and line ends outside records; R11 invalid colon
        send_char(8'h0D); send_char(8'h0A); send_char("x"); send_char("Z"); send_char("5");
        @(negedge clk); in_char = 8'h3A; in_valid = 1'b0;
        @(negedge clk);
        check(eof_done, "R1 R11 done kept through idle chars", eof_done, 1);
        check(log_n == 0 && fe_n == 0 && ce_n == 0, "R1 idle chars quiet", log_n + fe_n + ce_n, 0);
        send_char(8'h3A);
        check(!eof_done, "R7 colon clears done", eof_done, 0);
        send_char(8'h0D);
        check(fe_n == 1, "R5 line end inside record", fe_n, 1);
        clear_logs();

        // random records
        for (int r = 0; r < 40; r++) begin
            int cnt;
            logic [15:0] addr;
            logic [7:0] typ;
            logic bad;
            logic lower;
            cnt   = $urandom % 17;
            addr  = 16'($urandom);
            typ   = ($urandom % 8 == 0) ? 8'h02 : 8'h00;
            bad   = ($urandom % 6 == 0);
            lower = $urandom % 2;
            for (int i = 0; i < cnt; i++) rec_data[i] = 8'($urandom);
            if ($urandom % 2 == 0) begin send_char(8'h0D); send_char(8'h0A); end
            send_rec(cnt, addr, typ, bad, lower);
            verify_rec(cnt, addr, typ, bad, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule